// File: doc/BRIEF.md
# Planar Video Memory Write Datapath

This block turns one host byte write into the 32-bit word that is stored across four 8-bit display memory planes, which the memory side treats as a single word. The word is built from the host byte, a 32-bit latch that holds the previous contents of the addressed word, and a set of configuration inputs. These inputs are a write mode, a rotate count, a per-plane set/reset colour with its per-plane enable, a logical operation, a bit mask and a per-plane write enable. Plane p occupies bits [8p+7:8p] of every 32-bit word.

The result is registered. One clock after a write request, the block presents the word together with a write-valid flag and a 4-bit plane strobe, and a memory controller commits the strobed planes. Planes whose strobe is low carry the latch byte, so a full-word store also leaves them unchanged. Loading the latch, decoding the address and the memory array itself are handled elsewhere.

Top module: `pvw_write_path`

## Requirements
- R1: After reset, wr_valid is 0, plane_stb is 0000 and wr_data is zero until the first write request.
- R2: A write request sampled at a rising edge produces wr_valid = 1 with its wr_data and plane_stb after that same edge. Back-to-back requests give one result per cycle. A cycle without a request gives wr_valid = 0 and plane_stb = 0000 after the next edge.
- R3: In modes 0 and 3 the host byte is rotated right by rot_cnt (0 to 7) with wraparound, so that result bit b equals host bit (b + rot_cnt) mod 8.
- R4: In mode 0 (wmode = 00) every plane receives the rotated byte, except a plane whose sr_en bit is 1. That plane receives 8 copies of its sr_val bit.
- R5: The logical operation code lop selects 00 = pass the data, 01 = data AND latch, 10 = data OR latch, 11 = data XOR latch. The operation is applied bitwise per plane in modes 0, 2 and 3.
- R6: In modes 0 and 2 the 8-bit bit_mask applies to every plane. A mask bit of 1 takes the operation result and a mask bit of 0 takes the matching latch bit.
- R7: In mode 1 (wmode = 01) wr_data equals latch_word on all 32 bits. The host byte, rot_cnt, lop, bit_mask and set/reset inputs have no effect.
- R8: In mode 2 (wmode = 10) plane n receives 8 copies of host bit n for n = 0 to 3. Host bits 7 to 4 have no effect.
- R9: In mode 3 (wmode = 11) plane p receives 8 copies of sr_val bit p, whatever sr_en holds. The effective mask is the rotated host byte ANDed with bit_mask.
- R10: plane_stb equals the plane_en value of the request. The wr_data byte of every plane whose plane_en bit is 0 equals that plane's latch byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Host byte write request for this cycle |
| host_byte | input | 8 | Host write data |
| wmode | input | 2 | Write mode 0 to 3 |
| rot_cnt | input | 3 | Right-rotate count for the host byte |
| lop | input | 2 | Logical operation code |
| sr_val | input | 4 | Set/reset colour, one bit per plane |
| sr_en | input | 4 | Per-plane set/reset enable for mode 0 |
| bit_mask | input | 8 | Bit mask shared by all planes |
| plane_en | input | 4 | Per-plane write enable |
| latch_word | input | 32 | Latched previous contents of all planes |
| wr_valid | output | 1 | Result present this cycle |
| wr_data | output | 32 | Word to store, plane p at bits [8p+7:8p] |
| plane_stb | output | 4 | Planes to be written |

## Verification
Every result is due exactly one clock after its request, because the only register between the inputs and the outputs is the output stage. The driver applies a request on a falling edge and pushes the expected word and strobe into a queue. The monitor then samples on the next falling edge, half a cycle after the capturing edge, and pops one entry for each valid result, so a result that is late, missing or extra shows up as a queue mismatch. Idle cycles are checked on the same falling edge for a low valid flag and a zero strobe.

// File: rtl/pvw_pkg.sv
package pvw_pkg;

   // Write mode encoding; the numeric values are visible on the wmode port.
   typedef enum logic [1:0] {
      WM_BLEND   = 2'b00,   // rotate, set/reset substitution, op, mask
      WM_LATCH   = 2'b01,   // latch copied unchanged
      WM_COLOR   = 2'b10,   // host low bits expanded per plane
      WM_STENCIL = 2'b11    // set/reset colour, host byte acts as mask
   } wmode_e;

   // Logical operation encoding applied against the latch.
   typedef enum logic [1:0] {
      LOP_PASS = 2'b00,
      LOP_AND  = 2'b01,
      LOP_OR   = 2'b10,
      LOP_XOR  = 2'b11
   } lop_e;

endpackage

// File: rtl/pvw_rotator.sv
// Rotate right of one lane, variant picked by a parameter.
module pvw_rotator #(
   parameter int LANE_W = 8,
   parameter bit BARREL = 1'b1,
   localparam int CNT_W = $clog2(LANE_W)
) (
   input  logic [LANE_W-1:0] din,
   input  logic [CNT_W-1:0]  cnt,
   output logic [LANE_W-1:0] dout
);

   if (LANE_W < 2 || (1 << CNT_W) != LANE_W) begin : g_bad_width
      $error("pvw_rotator: LANE_W must be a power of two of at least 2");
   end

   if (BARREL) begin : g_barrel
      // log2(LANE_W) stages, stage s rotates by 2**s when cnt[s] is set
      logic [LANE_W-1:0] stage [0:CNT_W];
      assign stage[0] = din;
      for (genvar s = 0; s < CNT_W; s++) begin : g_stage
         localparam int AMT = 1 << s;
         assign stage[s+1] = cnt[s]
            ? {stage[s][AMT-1:0], stage[s][LANE_W-1:AMT]}
            : stage[s];
      end
      assign dout = stage[CNT_W];
   end else begin : g_shift
      // doubled vector shifted once; one wide shifter instead of stages
      logic [2*LANE_W-1:0] twice;
      always_comb begin
         twice = {din, din} >> cnt;
      end
      assign dout = twice[LANE_W-1:0];
   end

   // R3: a rotation neither creates nor loses set bits
   always_comb begin
      a_r3_bits_kept: assert ($countones(dout) == $countones(din));
   end

endmodule

// File: rtl/pvw_source_sel.sv
// Per-plane source data and per-plane mask, chosen by write mode.
module pvw_source_sel
   import pvw_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int LANE_W = 8,
   localparam int WORD_W = PLANES * LANE_W
) (
   input  wmode_e             mode,
   input  logic [LANE_W-1:0]  host_byte,
   input  logic [LANE_W-1:0]  rot_byte,
   input  logic [PLANES-1:0]  sr_val,
   input  logic [PLANES-1:0]  sr_en,
   input  logic [LANE_W-1:0]  bit_mask,
   output logic [WORD_W-1:0]  src_word,
   output logic [WORD_W-1:0]  mask_word,
   output logic               bypass
);

   if (PLANES > LANE_W) begin : g_bad_planes
      $error("pvw_source_sel: colour expansion needs PLANES <= LANE_W");
   end

   assign bypass = (mode == WM_LATCH);

   for (genvar p = 0; p < PLANES; p++) begin : g_plane
      logic [LANE_W-1:0] sr_fill;
      logic [LANE_W-1:0] host_fill;
      logic [LANE_W-1:0] src_l;
      logic [LANE_W-1:0] mask_l;

      assign sr_fill   = {LANE_W{sr_val[p]}};
      assign host_fill = {LANE_W{host_byte[p]}};

      always_comb begin
         unique case (mode)
            WM_BLEND: begin
               src_l  = sr_en[p] ? sr_fill : rot_byte;
               mask_l = bit_mask;
            end
            WM_LATCH: begin
               src_l  = '0;
               mask_l = '0;
            end
            WM_COLOR: begin
               src_l  = host_fill;
               mask_l = bit_mask;
            end
            WM_STENCIL: begin
               src_l  = sr_fill;
               mask_l = rot_byte & bit_mask;
            end
            default: begin
               src_l  = '0;
               mask_l = '0;
            end
         endcase
      end

      assign src_word [p*LANE_W +: LANE_W] = src_l;
      assign mask_word[p*LANE_W +: LANE_W] = mask_l;

      // R9: in the colour-fill stencil mode the mask never exceeds bit_mask
      always_comb begin
         if (mode == WM_STENCIL) begin
            a_r9_mask_within: assert ((mask_l & ~bit_mask) == '0);
         end
      end
   end

endmodule

// File: rtl/pvw_combine.sv
// Logical operation, bit-mask merge and plane-enable merge per plane.
module pvw_combine
   import pvw_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int LANE_W = 8,
   localparam int WORD_W = PLANES * LANE_W
) (
   input  lop_e               lop,
   input  logic               bypass,
   input  logic [WORD_W-1:0]  src_word,
   input  logic [WORD_W-1:0]  mask_word,
   input  logic [WORD_W-1:0]  latch_word,
   input  logic [PLANES-1:0]  plane_en,
   output logic [WORD_W-1:0]  result
);

   for (genvar p = 0; p < PLANES; p++) begin : g_plane
      logic [LANE_W-1:0] d_l;
      logic [LANE_W-1:0] m_l;
      logic [LANE_W-1:0] l_l;
      logic [LANE_W-1:0] op_l;
      logic [LANE_W-1:0] blend_l;
      logic [LANE_W-1:0] out_l;

      assign d_l = src_word  [p*LANE_W +: LANE_W];
      assign m_l = mask_word [p*LANE_W +: LANE_W];
      assign l_l = latch_word[p*LANE_W +: LANE_W];

      always_comb begin
         unique case (lop)
            LOP_PASS: op_l = d_l;
            LOP_AND:  op_l = d_l & l_l;
            LOP_OR:   op_l = d_l | l_l;
            LOP_XOR:  op_l = d_l ^ l_l;
            default:  op_l = d_l;
         endcase
      end

      assign blend_l = (op_l & m_l) | (l_l & ~m_l);
      assign out_l   = (bypass || !plane_en[p]) ? l_l : blend_l;
      assign result[p*LANE_W +: LANE_W] = out_l;

      // R6: every unmasked bit of an enabled plane keeps the latch value
      always_comb begin
         a_r6_unmasked_keep: assert (((out_l ^ l_l) & ~m_l) == '0);
      end
   end

endmodule

// File: rtl/pvw_write_path.sv
// Registered write datapath for four planes read and written as one word.
module pvw_write_path
   import pvw_pkg::*;
#(
   parameter int PLANES     = 4,
   parameter int LANE_W     = 8,
   parameter bit ROT_BARREL = 1'b1,
   localparam int WORD_W = PLANES * LANE_W,
   localparam int CNT_W  = $clog2(LANE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [LANE_W-1:0] host_byte,
   input  logic [1:0]        wmode,
   input  logic [CNT_W-1:0]  rot_cnt,
   input  logic [1:0]        lop,
   input  logic [PLANES-1:0] sr_val,
   input  logic [PLANES-1:0] sr_en,
   input  logic [LANE_W-1:0] bit_mask,
   input  logic [PLANES-1:0] plane_en,
   input  logic [WORD_W-1:0] latch_word,
   output logic              wr_valid,
   output logic [WORD_W-1:0] wr_data,
   output logic [PLANES-1:0] plane_stb
);

   if (PLANES < 1) begin : g_bad_planes
      $error("pvw_write_path: PLANES must be at least 1");
   end

   wmode_e            mode_q;
   lop_e              lop_q;
   logic [LANE_W-1:0] rot_byte;
   logic [WORD_W-1:0] src_word;
   logic [WORD_W-1:0] mask_word;
   logic              bypass;
   logic [WORD_W-1:0] next_word;

   assign mode_q = wmode_e'(wmode);
   assign lop_q  = lop_e'(lop);

   pvw_rotator #(
      .LANE_W (LANE_W),
      .BARREL (ROT_BARREL)
   ) u_rot (
      .din  (host_byte),
      .cnt  (rot_cnt),
      .dout (rot_byte)
   );

   pvw_source_sel #(
      .PLANES (PLANES),
      .LANE_W (LANE_W)
   ) u_src (
      .mode      (mode_q),
      .host_byte (host_byte),
      .rot_byte  (rot_byte),
      .sr_val    (sr_val),
      .sr_en     (sr_en),
      .bit_mask  (bit_mask),
      .src_word  (src_word),
      .mask_word (mask_word),
      .bypass    (bypass)
   );

   pvw_combine #(
      .PLANES (PLANES),
      .LANE_W (LANE_W)
   ) u_comb (
      .lop        (lop_q),
      .bypass     (bypass),
      .src_word   (src_word),
      .mask_word  (mask_word),
      .latch_word (latch_word),
      .plane_en   (plane_en),
      .result     (next_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_valid  <= 1'b0;
         wr_data   <= '0;
         plane_stb <= '0;
      end else begin
         wr_valid  <= wr_req;
         plane_stb <= wr_req ? plane_en : '0;
         if (wr_req) begin
            wr_data <= next_word;
         end
      end
   end

   // R2: one result per request, exactly one cycle later
   a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> wr_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |=> !wr_valid);

   // R10: strobes are quiet when idle and copy the request's plane enable
   a_r10_stb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |-> plane_stb == '0);
   a_r10_stb_copy: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> plane_stb == $past(plane_en));

   // R7: latch copy mode returns the latch whatever the other inputs hold
   a_r7_latch_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wmode == 2'b01) |=> wr_data == $past(latch_word));

   // R10: a disabled plane carries its latch byte
   for (genvar p = 0; p < PLANES; p++) begin : g_keep_chk
      a_r10_keep_lane: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_req && !plane_en[p]) |=>
            wr_data[p*LANE_W +: LANE_W] == $past(latch_word[p*LANE_W +: LANE_W]));
   end

endmodule

// File: tb/pvw_write_path_bench.sv
`timescale 1ns/1ps
module pvw_write_path_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_req = 1'b0;
   logic [7:0]  host_byte = '0;
   logic [1:0]  wmode = '0;
   logic [2:0]  rot_cnt = '0;
   logic [1:0]  lop = '0;
   logic [3:0]  sr_val = '0;
   logic [3:0]  sr_en = '0;
   logic [7:0]  bit_mask = '0;
   logic [3:0]  plane_en = '0;
   logic [31:0] latch_word = '0;
   logic        wr_valid;
   logic [31:0] wr_data;
   logic [3:0]  plane_stb;

   always #4 clk = ~clk;   // 125 MHz

   pvw_write_path u_pvw_write_path (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .host_byte(host_byte),
      .wmode(wmode), .rot_cnt(rot_cnt), .lop(lop), .sr_val(sr_val),
      .sr_en(sr_en), .bit_mask(bit_mask), .plane_en(plane_en),
      .latch_word(latch_word), .wr_valid(wr_valid), .wr_data(wr_data),
      .plane_stb(plane_stb)
   );

   typedef struct {
      string       tag;
      logic [31:0] data;
      logic [3:0]  stb;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   bit   mon_on = 1'b0;

   task automatic check(string tag, bit ok, logic [35:0] act, logic [35:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Reference model written from the requirements, bit by bit.
   function automatic logic [31:0] model(logic [1:0] m, logic [7:0] h, logic [2:0] r,
         logic [1:0] op, logic [3:0] sv, logic [3:0] se, logic [7:0] bm,
         logic [3:0] pe, logic [31:0] la);
      logic [31:0] w;
      logic [7:0]  rb;
      for (int b = 0; b < 8; b++) rb[b] = h[(b + r) % 8];
      for (int p = 0; p < 4; p++) begin
         for (int b = 0; b < 8; b++) begin
            logic d, k, l, o;
            l = la[p*8 + b];
            case (m)
               2'd0: begin d = se[p] ? sv[p] : rb[b]; k = bm[b]; end
               2'd2: begin d = h[p]; k = bm[b]; end
               2'd3: begin d = sv[p]; k = rb[b] & bm[b]; end
               default: begin d = l; k = 1'b0; end
            endcase
            case (op)
               2'd0: o = d;
               2'd1: o = d & l;
               2'd2: o = d | l;
               default: o = d ^ l;
            endcase
            w[p*8 + b] = (m == 2'd1 || !pe[p]) ? l : (k ? o : l);
         end
      end
      return w;
   endfunction

   // Driver: apply one request on a falling edge and queue its expectation.
   task automatic drive(string tag, logic [1:0] m, logic [7:0] h, logic [2:0] r,
         logic [1:0] op, logic [3:0] sv, logic [3:0] se, logic [7:0] bm,
         logic [3:0] pe, logic [31:0] la);
      exp_t e;
      @(negedge clk);
      wr_req = 1'b1; wmode = m; host_byte = h; rot_cnt = r; lop = op;
      sr_val = sv; sr_en = se; bit_mask = bm; plane_en = pe; latch_word = la;
      e.tag = tag;
      e.data = model(m, h, r, op, sv, se, bm, pe, la);
      e.stb = pe;
      q.push_back(e);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_req = 1'b0;
         host_byte = 8'hA5;
      end
   endtask

   // Monitor: results are due one edge after their request.
   always @(negedge clk) begin
      if (mon_on) begin
         if (wr_valid) begin
            if (q.size() == 0) begin
               check("R2 unexpected result", 1'b0, {4'h0, wr_data}, 36'h0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(e.tag, wr_data == e.data && plane_stb == e.stb,
                     {plane_stb, wr_data}, {e.stb, e.data});
            end
         end else begin
            check("R2 idle strobe", plane_stb == 4'h0, {plane_stb, 32'h0}, 36'h0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset", !wr_valid && plane_stb == 4'h0 && wr_data == 32'h0,
            {plane_stb, wr_data}, 36'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", !wr_valid && wr_data == 32'h0,
            {3'b0, wr_valid, wr_data}, 36'h0);
      mon_on = 1'b1;

      // R3: rotate counts 1, 7, 0
      drive("R3 rot1", 2'd0, 8'h81, 3'd1, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 32'h0);
      drive("R3 rot7", 2'd0, 8'h81, 3'd7, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 32'h0);
      drive("R3 rot0", 2'd0, 8'h3C, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 32'h12345678);
      idle(2);
      // R4: set/reset substitution on planes 0 and 2
      drive("R4 sr sub", 2'd0, 8'h3C, 3'd2, 2'd0, 4'b0100, 4'b0101, 8'hFF, 4'hF, 32'hFFFF0000);
      drive("R4 sr all", 2'd0, 8'h00, 3'd0, 2'd0, 4'b1010, 4'hF, 8'hFF, 4'hF, 32'h0);
      idle(1);
      // R5: each logical operation
      drive("R5 pass", 2'd0, 8'hF0, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 32'h5A5A5A5A);
      drive("R5 and",  2'd0, 8'hF0, 3'd0, 2'd1, 4'h0, 4'h0, 8'hFF, 4'hF, 32'h5A5A5A5A);
      drive("R5 or",   2'd0, 8'hF0, 3'd0, 2'd2, 4'h0, 4'h0, 8'hFF, 4'hF, 32'h5A5A5A5A);
      drive("R5 xor",  2'd0, 8'hF0, 3'd0, 2'd3, 4'h0, 4'h0, 8'hFF, 4'hF, 32'h5A5A5A5A);
      idle(1);
      // R6: partial masks in modes 0 and 2
      drive("R6 mask m0", 2'd0, 8'hFF, 3'd0, 2'd0, 4'h0, 4'h0, 8'h0F, 4'hF, 32'hC3C3C3C3);
      drive("R6 mask m2", 2'd2, 8'h0F, 3'd0, 2'd0, 4'h0, 4'h0, 8'h81, 4'hF, 32'h00000000);
      idle(1);
      // R7: latch copy, other inputs varied, no effect
      drive("R7 latch a", 2'd1, 8'h00, 3'd0, 2'd0, 4'h0, 4'h0, 8'h00, 4'hF, 32'hDEADBEEF);
      drive("R7 latch b", 2'd1, 8'hFF, 3'd5, 2'd3, 4'hF, 4'hF, 8'hFF, 4'hF, 32'hDEADBEEF);
      idle(1);
      // R8: colour expansion, upper host bits ignored
      drive("R8 expand", 2'd2, 8'h05, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 32'h0);
      drive("R8 upper ignored", 2'd2, 8'hF5, 3'd3, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 32'h0);
      idle(1);
      // R9: stencil mode, sr_en ignored, mask = rotated host & bit_mask
      drive("R9 stencil", 2'd3, 8'hF0, 3'd4, 2'd0, 4'b0110, 4'h0, 8'h3C, 4'hF, 32'hAAAAAAAA);
      drive("R9 stencil sr_en", 2'd3, 8'hF0, 3'd4, 2'd0, 4'b0110, 4'hF, 8'h3C, 4'hF, 32'hAAAAAAAA);
      idle(1);
      // R10: plane enable patterns
      drive("R10 pe 1010", 2'd0, 8'hFF, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'b1010, 32'h11223344);
      drive("R10 pe 0000", 2'd2, 8'h0F, 3'd0, 2'd3, 4'h0, 4'h0, 8'hFF, 4'b0000, 32'h55667788);
      // R2: back-to-back then idle
      drive("R2 b2b 1", 2'd0, 8'h01, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 32'h0);
      drive("R2 b2b 2", 2'd0, 8'h02, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 32'h0);
      idle(3);
      // R6: varied sweep over all modes and settings
      for (int i = 0; i < 60; i++) begin
         drive("R6 sweep", 2'($urandom), 8'($urandom), 3'($urandom), 2'($urandom),
               4'($urandom), 4'($urandom), 8'($urandom), 4'($urandom), $urandom);
         if (i % 7 == 0) idle(1);
      end
      idle(3);
      check("R2 queue drained", q.size() == 0, 36'(q.size()), 36'h0);
      check("R2 idle valid", !wr_valid, {35'h0, wr_valid}, 36'h0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule